// File: doc/BRIEF.md
# Serial/Parallel Latched Switch-Control Register

This block holds a 6-bit control word that drives a bank of switch-control outputs. The word is first built in a staging register and only then moved to the outputs. It can reach the staging register in two ways. In serial mode it is shifted in over a three-wire link made of data, clock and latch enable, most-significant bit first. In parallel mode the staging register follows six input pins. A mode-select pin picks the source. While latch enable is high, the staged word is copied to the outputs and serial clock edges are masked. While latch enable is low, the outputs do not move.

Every external input passes through a two-flop synchronizer clocked by a system clock. That clock must run at least eight times faster than the serial clock. A rising serial-clock edge is found by comparing the synchronized level with its value one cycle earlier.

A four-state machine follows the synchronized {mode-select, latch-enable} pair. The machine is re-evaluated on every cycle, and any state can move to any other, so each state is entered directly from whatever state the machine is in.

| State | Condition | Staging register | Outputs |
|---|---|---|---|
| `ST_SER_SHIFT` | mode 1, latch 0 | shifts one bit per serial-clock rising edge | hold |
| `ST_SER_XFER` | mode 1, latch 1 | frozen | load the staged word |
| `ST_PAR_STAGE` | mode 0, latch 0 | follows the pins | hold |
| `ST_PAR_FLOW` | mode 0, latch 1 | follows the pins | load the staged word, so the pins flow through |

The named transitions are:
- latch rise: SHIFT→XFER or STAGE→FLOW
- latch fall: XFER→SHIFT or FLOW→STAGE
- mode fall: to a parallel state
- mode rise: to a serial state

Top module: `swctl_latch_reg`

## Requirements
- R1: While reset is asserted, and immediately after it is released, the staging register and `ctl_out` are all zero.
- R2: In serial mode (`mode_sel`=1) with `latch_en` low, each rising edge of `ser_clk` shifts `ser_data` into bit 0 of the staging register and moves the older bits up one place. After six edges, the first bit sent sits in bit 5.
- R3: When more than six bits are shifted in before a latch, the staging register keeps only the last six bits received.
- R4: Rising edges of `ser_clk` while `latch_en` is high do not change the staged word.
- R5: While `latch_en` is low, `ctl_out` holds its value in both modes.
- R6: While `latch_en` is high, `ctl_out` takes the staged word one system clock after the staging register.
- R7: In parallel mode (`mode_sel`=0), `ser_clk` and `ser_data` have no effect, and the staging register follows `par_in` with `par_in[5]` in bit 5.
- R8: When `latch_en` is held high in parallel mode, `ctl_out` tracks changes of `par_in` with no further latch pulse.
- R9: In parallel mode with `latch_en` low, changes on `par_in` do not reach `ctl_out`. A single later `latch_en` pulse applies the settled value.
- R10: A change at the pins reaches `ctl_out` exactly 4 system clocks after the pins are sampled: 2 synchronizer stages, 1 decode stage, 1 staging stage and then the output stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 1 | 1 = serial load, 0 = parallel load |
| latch_en | input | 1 | Transfers the staged word to the outputs while high |
| ser_clk | input | 1 | Serial shift clock, rising-edge active |
| ser_data | input | 1 | Serial data, MSB first |
| par_in | input | 6 | Parallel control word |
| ctl_out | output | 6 | Registered switch-control outputs |

## Verification
The word is loaded in four ways, and each pattern separates a different fault:
- **Serial, exactly six bits, with an asymmetric value.** This catches bit-order and shift-direction errors.
- **Serial, eight bits.** This shows whether the extra leading bits are dropped.
- **Serial clocks sent while latch is high.** This catches a missing clock mask.
- **Parallel, in both latched and flow-through use.** This shows whether the pins leak to the outputs while latch is low, and whether they track the outputs while latch is held high.

A final return from parallel to serial mode confirms that shifting resumes from the word the pins left in the staging register. A behavioural model with a queue of input history is compared with `ctl_out` on every clock. This model pins down the exact latency.

// File: rtl/swctl_pkg.sv
package swctl_pkg;
    localparam int CTL_W = 6;

    typedef enum logic [1:0] {
        ST_SER_SHIFT = 2'b00,
        ST_SER_XFER  = 2'b01,
        ST_PAR_STAGE = 2'b10,
        ST_PAR_FLOW  = 2'b11
    } swctl_state_e;
endpackage

// File: rtl/swctl_sync.sv
module swctl_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= '0;
                    else        chain[g] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= '0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/swctl_decode.sv
module swctl_decode
    import swctl_pkg::*;
#(
    parameter int W = CTL_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         s_mode,
    input  logic         s_le,
    input  logic         s_sclk,
    input  logic         s_sdat,
    input  logic [W-1:0] s_par,
    output swctl_state_e state_q,
    output logic         shift_pulse_q,
    output logic         sdat_q,
    output logic [W-1:0] par_q
);
    swctl_state_e state_d;
    logic         sclk_d;
    logic         sclk_rise;

    always_comb begin
        unique case ({s_mode, s_le})
            2'b10:   state_d = ST_SER_SHIFT;
            2'b11:   state_d = ST_SER_XFER;
            2'b00:   state_d = ST_PAR_STAGE;
            default: state_d = ST_PAR_FLOW;
        endcase
    end

    assign sclk_rise = s_sclk & ~sclk_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PAR_STAGE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d        <= 1'b0;
            shift_pulse_q <= 1'b0;
            sdat_q        <= 1'b0;
            par_q         <= '0;
        end else begin
            sclk_d        <= s_sclk;
            shift_pulse_q <= sclk_rise;
            sdat_q        <= s_sdat;
            par_q         <= s_par;
        end
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        shift_pulse_q |=> !shift_pulse_q); // R2
endmodule

// File: rtl/swctl_latch_reg.sv
module swctl_latch_reg
    import swctl_pkg::*;
#(
    parameter int W         = CTL_W,
    parameter int SYNC_DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_sel,
    input  logic         latch_en,
    input  logic         ser_clk,
    input  logic         ser_data,
    input  logic [W-1:0] par_in,
    output logic [W-1:0] ctl_out
);
    localparam int BUS_W = W + 4;

    logic [BUS_W-1:0] raw_bus;
    logic [BUS_W-1:0] syn_bus;
    swctl_state_e     state_q;
    logic             shift_pulse_q;
    logic             sdat_q;
    logic [W-1:0]     par_q;
    logic [W-1:0]     stage_q;

    assign raw_bus = {mode_sel, latch_en, ser_clk, ser_data, par_in};

    swctl_sync #(.W(BUS_W), .STAGES(SYNC_DEPTH)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_bus),
        .dout (syn_bus)
    );

    swctl_decode #(.W(W)) u_decode (
        .clk          (clk),
        .rst_n        (rst_n),
        .s_mode       (syn_bus[W+3]),
        .s_le         (syn_bus[W+2]),
        .s_sclk       (syn_bus[W+1]),
        .s_sdat       (syn_bus[W]),
        .s_par        (syn_bus[W-1:0]),
        .state_q      (state_q),
        .shift_pulse_q(shift_pulse_q),
        .sdat_q       (sdat_q),
        .par_q        (par_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            unique case (state_q)
                ST_SER_SHIFT: if (shift_pulse_q) stage_q <= {stage_q[W-2:0], sdat_q};
                ST_SER_XFER:  stage_q <= stage_q;
                ST_PAR_STAGE,
                ST_PAR_FLOW:  stage_q <= par_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_out <= '0;
        end else begin
            unique case (state_q)
                ST_SER_XFER,
                ST_PAR_FLOW:  ctl_out <= stage_q;
                ST_SER_SHIFT,
                ST_PAR_STAGE: ctl_out <= ctl_out;
            endcase
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $rose(rst_n) |-> (ctl_out == '0 && stage_q == '0)); // R1
    AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SER_SHIFT && shift_pulse_q)
            |=> stage_q == {$past(stage_q[W-2:0]), $past(sdat_q)}); // R2
    AST_STAGE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SER_XFER) |=> $stable(stage_q)); // R4
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SER_SHIFT || state_q == ST_PAR_STAGE) |=> $stable(ctl_out)); // R5
    AST_OUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SER_XFER || state_q == ST_PAR_FLOW) |=> ctl_out == $past(stage_q)); // R6
    AST_PAR_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAR_STAGE || state_q == ST_PAR_FLOW) |=> stage_q == $past(par_q)); // R7
endmodule

// File: tb/swctl_latch_reg_tb.sv
module swctl_latch_reg_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_sel = 1'b1;
    logic       latch_en = 1'b0;
    logic       ser_clk = 1'b0;
    logic       ser_data = 1'b0;
    logic [5:0] par_in = '0;
    logic [5:0] ctl_out;

    int    total = 0;
    int    bad = 0;
    string cur_req = "R1";
    bit    finished = 1'b0;

    logic [9:0] hist [$];
    logic [5:0] m_stage;
    logic [5:0] m_out;

    always #2 clk = ~clk;

    swctl_latch_reg dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_sel(mode_sel),
        .latch_en(latch_en),
        .ser_clk (ser_clk),
        .ser_data(ser_data),
        .par_in  (par_in),
        .ctl_out (ctl_out)
    );

    task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model (R10 latency): sample k drives staging at k+3, outputs at k+4
    always @(posedge clk) begin
        if (!rst_n) begin
            hist.delete();
            for (int i = 0; i < 8; i++) hist.push_back('0);
            m_stage = '0;
            m_out   = '0;
        end else begin
            logic [9:0] a;
            logic [9:0] b;
            logic [5:0] nxt_out;
            hist.push_front({mode_sel, latch_en, ser_clk, ser_data, par_in});
            void'(hist.pop_back());
            a = hist[3];
            b = hist[4];
            nxt_out = a[8] ? m_stage : m_out;
            if (!a[9])
                m_stage = a[5:0];
            else if (!a[8] && a[7] && !b[7])
                m_stage = {m_stage[4:0], a[6]};
            m_out = nxt_out;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) check({cur_req, "/R10"}, ctl_out, m_out);
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        ser_data = b;
        wait_cyc(6);
        ser_clk = 1'b1;
        wait_cyc(12);
        ser_clk = 1'b0;
        wait_cyc(12);
    endtask

    task automatic pulse_latch();
        latch_en = 1'b1;
        wait_cyc(5);
        latch_en = 1'b0;
        wait_cyc(160);
    endtask

    initial begin
        wait_cyc(5);
        check("R1", ctl_out, 6'b000000);
        rst_n = 1'b1;
        wait_cyc(3);
        check("R1", ctl_out, 6'b000000);

        cur_req = "R2";
        wait_cyc(10);
        for (int i = 5; i >= 0; i--) send_bit(6'b101100 >> i);
        check("R5", ctl_out, 6'b000000);
        pulse_latch();
        check("R2", ctl_out, 6'b101100);
        check("R6", ctl_out, 6'b101100);

        cur_req = "R3";
        for (int i = 7; i >= 0; i--) send_bit(8'b11010011 >> i);
        check("R5", ctl_out, 6'b101100);
        pulse_latch();
        check("R3", ctl_out, 6'b010011);

        cur_req = "R4";
        latch_en = 1'b1;
        wait_cyc(10);
        for (int i = 0; i < 3; i++) send_bit(1'b1);
        check("R4", ctl_out, 6'b010011);
        latch_en = 1'b0;
        wait_cyc(160);
        pulse_latch();
        check("R4", ctl_out, 6'b010011);

        cur_req = "R7";
        mode_sel = 1'b0;
        par_in = 6'b111000;
        wait_cyc(10);
        for (int i = 0; i < 3; i++) send_bit(i[0]);
        check("R9", ctl_out, 6'b010011);
        pulse_latch();
        check("R7", ctl_out, 6'b111000);
        check("R9", ctl_out, 6'b111000);

        cur_req = "R8";
        latch_en = 1'b1;
        par_in = 6'b000111;
        wait_cyc(10);
        check("R8", ctl_out, 6'b000111);
        par_in = 6'b101010;
        wait_cyc(10);
        check("R8", ctl_out, 6'b101010);
        latch_en = 1'b0;
        wait_cyc(160);

        cur_req = "R2";
        mode_sel = 1'b1;
        par_in = 6'b010101;
        wait_cyc(10);
        send_bit(1'b1);
        send_bit(1'b1);
        check("R5", ctl_out, 6'b101010);
        pulse_latch();
        check("R2", ctl_out, 6'b101011);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule